// File: doc/BRIEF.md
# Timing Reference Clipper and Detector

This block sits in a serial video transmit path between the parallel input register and the scrambler. Each accepted input word is first brought to 10 bits (an 8-bit source is widened), then passed through a short word delay. While the word stream is in the delay, the block looks for a timing reference: three preamble words (top code, bottom code, bottom code) followed by a code word. The low two bits of the preamble words are tolerated, so a preamble word in the 3FCh..3FFh band is rewritten to exactly 3FFh and a word in the 000h..003h band to exactly 000h before it leaves. Because of the delay, the first preamble word can still be corrected once the whole preamble has been seen.

The code word leaves unchanged. Bit 4 of the code word tells a start-of-line reference (0) from an end-of-line reference (1), and the block flags it on the output side together with the code word. A region flag marks output words of active video: words after a start reference and up to the next end reference, excluding reference words themselves. Detection is controlled by an active-low enable. When it is high, words pass through unchanged and no flags are raised.

Top module: `trs_clip_detect`

## Requirements
- R1: While reset is asserted, word_out is 000h and word_out_vld, trs_hit, trs_is_sav, trs_is_eav and active_video are all 0; all detection state is cleared.
- R2: Each accepted word (word_in_vld high at a clock edge) enters a DEPTH-word delay; at that edge word_out takes the word accepted DEPTH-1 acceptances earlier (three with the default DEPTH of 4), initially 000h.
- R3: When a reference is detected, the first preamble word (any value 3FCh..3FFh) leaves as exactly 3FFh.
- R4: When a reference is detected, the second and third preamble words (any value 000h..003h) leave as exactly 000h.
- R5: A sequence with a preamble word outside those bands (for example 3FBh or 004h) is not a reference: nothing is rewritten and no flag is raised.
- R6: A reference is detected when its code word is accepted; when that code word is on word_out with word_out_vld high, trs_hit is 1 and exactly one of trs_is_eav (code word bit 4 = 1) or trs_is_sav (bit 4 = 0) is 1; the code word itself is not changed.
- R7: If det_enable_n is 1 when the code word is accepted, the sequence is not detected: no rewriting, no trs_hit, trs_is_sav or trs_is_eav.
- R8: With narrow_mode = 1 only word_in[7:0] is used; it is widened to {word_in[7:0], 2'b00}, except that FFh widens to 3FFh.
- R9: active_video is 1 on an output cycle (word_out_vld high) whose word follows a start reference code word on the output and precedes the next end reference, and is 0 on preamble and code words; any clock with det_enable_n = 1 clears the region.
- R10: In a cycle after an edge with word_in_vld low, word_out_vld is 0 and word_out holds its value; word_out_vld is 1 for one cycle after each acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_in | input | 10 | Input word (bits 7:0 in narrow mode) |
| word_in_vld | input | 1 | Input word is accepted at this edge |
| narrow_mode | input | 1 | 1: 8-bit source words |
| det_enable_n | input | 1 | Reference detection enable, active low |
| word_out | output | 10 | Corrected, delayed word for the scrambler |
| word_out_vld | output | 1 | A new word is on word_out |
| trs_hit | output | 1 | word_out is a reference code word |
| trs_is_sav | output | 1 | The reference is a start-of-line reference |
| trs_is_eav | output | 1 | The reference is an end-of-line reference |
| active_video | output | 1 | word_out is an active video word |

## Verification
The hardest situation to reach is a reference whose preamble straddles stall cycles and detection-enable changes, because the rewrite of the oldest preamble word happens on the same edge that pushes it to the output. The stimulus sends references with noisy low bits in both word widths, interleaves random idle cycles inside the preamble, drops the enable for a single clock in the middle of an active region, and places near-miss preambles one code outside each band, while a behavioural queue model predicts every output on every clock.

// File: rtl/trs_pkg.sv
package trs_pkg;

  localparam int WORD_W   = 10;
  localparam int NARROW_W = 8;

  typedef logic [WORD_W-1:0] vword_t;

  // Role of a word held in the delay line.
  typedef enum logic [1:0] {
    TAG_NONE = 2'd0,
    TAG_PRE  = 2'd1,
    TAG_SAV  = 2'd2,
    TAG_EAV  = 2'd3
  } trs_tag_e;

  // 8-bit source word to 10-bit word: two zero LSBs, all ones stays all ones.
  function automatic vword_t widen_narrow(logic [NARROW_W-1:0] b);
    if (&b) return '1;
    return {b, {(WORD_W-NARROW_W){1'b0}}};
  endfunction

  // Word lies in the top band once the low clip bits are ignored.
  function automatic logic near_top(vword_t w, int unsigned clip);
    vword_t ones;
    ones = '1;
    return (w >> clip) == (ones >> clip);
  endfunction

  // Word lies in the bottom band once the low clip bits are ignored.
  function automatic logic near_bottom(vword_t w, int unsigned clip);
    return (w >> clip) == '0;
  endfunction

endpackage

// File: rtl/trs_word_widen.sv
module trs_word_widen
  import trs_pkg::*;
(
  input  logic   narrow_mode,
  input  vword_t raw_word,
  output vword_t wide_word
);

  always_comb begin
    if (narrow_mode) wide_word = widen_narrow(raw_word[NARROW_W-1:0]);
    else             wide_word = raw_word;
  end

endmodule

// File: rtl/trs_preamble_match.sv
module trs_preamble_match
  import trs_pkg::*;
#(
  parameter int CLIP_BITS = 2
) (
  input  vword_t oldest,
  input  vword_t middle,
  input  vword_t newest,
  output logic   preamble_seen
);

  logic top_ok;
  logic mid_ok;
  logic new_ok;

  always_comb begin
    top_ok        = near_top(oldest, CLIP_BITS);
    mid_ok        = near_bottom(middle, CLIP_BITS);
    new_ok        = near_bottom(newest, CLIP_BITS);
    preamble_seen = top_ok & mid_ok & new_ok;
  end

endmodule

// File: rtl/trs_delay_line.sv
module trs_delay_line
  import trs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  vword_t   din,
  input  trs_tag_e din_tag,
  input  logic     clip_now,
  output vword_t   tap_new,
  output vword_t   tap_mid,
  output vword_t   tap_old,
  output vword_t   head_word,
  output trs_tag_e head_tag
);

  // Entry 0 is the newest word, entry DEPTH-1 is presented at the output.
  vword_t   mem  [DEPTH];
  trs_tag_e tags [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i]  <= '0;
        tags[i] <= TAG_NONE;
      end
    end else if (push) begin
      mem[0]  <= din;
      tags[0] <= din_tag;
      for (int i = 1; i < DEPTH; i++) begin
        mem[i]  <= mem[i-1];
        tags[i] <= tags[i-1];
      end
      if (clip_now) begin
        // The three preamble words move one place and are forced to their extremes.
        mem[3]  <= '1;
        mem[2]  <= '0;
        mem[1]  <= '0;
        tags[3] <= TAG_PRE;
        tags[2] <= TAG_PRE;
        tags[1] <= TAG_PRE;
      end
    end
  end

  assign tap_new   = mem[0];
  assign tap_mid   = mem[1];
  assign tap_old   = mem[2];
  assign head_word = mem[DEPTH-1];
  assign head_tag  = tags[DEPTH-1];

endmodule

// File: rtl/trs_region_tracker.sv
module trs_region_tracker
  import trs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     shift,
  input  logic     detect_off,
  input  trs_tag_e leaving_tag,
  output logic     in_region
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_region <= 1'b0;
    end else if (detect_off) begin
      in_region <= 1'b0;
    end else if (shift) begin
      case (leaving_tag)
        TAG_SAV: in_region <= 1'b1;
        TAG_EAV: in_region <= 1'b0;
        default: in_region <= in_region;
      endcase
    end
  end

endmodule

// File: rtl/trs_clip_detect.sv
module trs_clip_detect
  import trs_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int CLIP_BITS = 2,
  parameter int FLAG_BIT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_in,
  input  logic              word_in_vld,
  input  logic              narrow_mode,
  input  logic              det_enable_n,
  output logic [WORD_W-1:0] word_out,
  output logic              word_out_vld,
  output logic              trs_hit,
  output logic              trs_is_sav,
  output logic              trs_is_eav,
  output logic              active_video
);

  // DEPTH must be at least 4 so the oldest preamble word is still held
  // when the code word arrives.

  vword_t   wide_word;
  vword_t   tap_new;
  vword_t   tap_mid;
  vword_t   tap_old;
  vword_t   head_word;
  trs_tag_e head_tag;
  trs_tag_e new_tag;
  logic     preamble_seen;
  logic     match_fire;
  logic     in_region;
  logic     vld_q;

  trs_word_widen u_widen (
    .narrow_mode (narrow_mode),
    .raw_word    (word_in),
    .wide_word   (wide_word)
  );

  trs_preamble_match #(.CLIP_BITS(CLIP_BITS)) u_match (
    .oldest        (tap_old),
    .middle        (tap_mid),
    .newest        (tap_new),
    .preamble_seen (preamble_seen)
  );

  // Named event: a reference code word is accepted this cycle.
  assign match_fire = word_in_vld & ~det_enable_n & preamble_seen;

  always_comb begin
    if (!match_fire)              new_tag = TAG_NONE;
    else if (wide_word[FLAG_BIT]) new_tag = TAG_EAV;
    else                          new_tag = TAG_SAV;
  end

  trs_delay_line #(.DEPTH(DEPTH)) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (word_in_vld),
    .din       (wide_word),
    .din_tag   (new_tag),
    .clip_now  (match_fire),
    .tap_new   (tap_new),
    .tap_mid   (tap_mid),
    .tap_old   (tap_old),
    .head_word (head_word),
    .head_tag  (head_tag)
  );

  trs_region_tracker u_region (
    .clk         (clk),
    .rst_n       (rst_n),
    .shift       (word_in_vld),
    .detect_off  (det_enable_n),
    .leaving_tag (head_tag),
    .in_region   (in_region)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= word_in_vld;
  end

  assign word_out     = head_word;
  assign word_out_vld = vld_q;
  assign trs_is_sav   = vld_q & (head_tag == TAG_SAV);
  assign trs_is_eav   = vld_q & (head_tag == TAG_EAV);
  assign trs_hit      = trs_is_sav | trs_is_eav;
  assign active_video = vld_q & in_region & (head_tag == TAG_NONE);

endmodule

// File: rtl/trs_clip_detect_chk.sv
module trs_clip_detect_chk #(
  parameter int FLAG_BIT = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       word_in_vld,
  input logic       det_enable_n,
  input logic       match_fire,
  input logic [9:0] word_out,
  input logic       word_out_vld,
  input logic       trs_hit,
  input logic       trs_is_sav,
  input logic       trs_is_eav,
  input logic       active_video
);

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !word_in_vld |=> ($stable(word_out) && !word_out_vld));

  assert_first_pre_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    match_fire |=> (word_out == 10'h3FF));

  assert_kind_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trs_is_sav || trs_is_eav) |-> (trs_hit && word_out_vld && !(trs_is_sav && trs_is_eav)));

  assert_eav_flag_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trs_is_eav |-> word_out[FLAG_BIT]);

  assert_sav_flag_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trs_is_sav |-> !word_out[FLAG_BIT]);

  assert_ref_not_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trs_hit |-> !active_video);

  assert_off_clears_region_R9: assert property (@(posedge clk) disable iff (!rst_n)
    det_enable_n |=> !active_video);

endmodule

bind trs_clip_detect trs_clip_detect_chk #(.FLAG_BIT(FLAG_BIT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .word_in_vld  (word_in_vld),
  .det_enable_n (det_enable_n),
  .match_fire   (match_fire),
  .word_out     (word_out),
  .word_out_vld (word_out_vld),
  .trs_hit      (trs_hit),
  .trs_is_sav   (trs_is_sav),
  .trs_is_eav   (trs_is_eav),
  .active_video (active_video)
);

// File: tb/trs_clip_detect_test.sv
module trs_clip_detect_test;

  localparam int CLK_P = 10;
  localparam int LAT   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] word_in = '0;
  logic       word_in_vld = 1'b0;
  logic       narrow_mode = 1'b0;
  logic       det_enable_n = 1'b0;
  logic [9:0] word_out;
  logic       word_out_vld;
  logic       trs_hit;
  logic       trs_is_sav;
  logic       trs_is_eav;
  logic       active_video;

  trs_clip_detect uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_in      (word_in),
    .word_in_vld  (word_in_vld),
    .narrow_mode  (narrow_mode),
    .det_enable_n (det_enable_n),
    .word_out     (word_out),
    .word_out_vld (word_out_vld),
    .trs_hit      (trs_hit),
    .trs_is_sav   (trs_is_sav),
    .trs_is_eav   (trs_is_eav),
    .active_video (active_video)
  );

  always #(CLK_P/2) clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string phase = "R2";
  int    hits_seen = 0;
  int    sav_seen = 0;
  int    eav_seen = 0;

  // Reference model: queue index 0 is the word on the output.
  // Tags: 0 plain, 1 preamble, 2 start reference, 3 end reference.
  int m_word[$];
  int m_tag[$];
  bit m_vld;
  bit m_act;

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_word = '{0, 0, 0, 0};
      m_tag  = '{0, 0, 0, 0};
      m_vld  = 0;
      m_act  = 0;
    end else begin
      int w;
      int t;
      bit hit;
      if (det_enable_n) m_act = 0;
      else if (word_in_vld) begin
        if (m_tag[0] == 2) m_act = 1;
        else if (m_tag[0] == 3) m_act = 0;
      end
      if (word_in_vld) begin
        if (narrow_mode) w = (word_in[7:0] == 8'hFF) ? 1023 : int'(word_in[7:0]) * 4;
        else             w = int'(word_in);
        hit = !det_enable_n && m_word[1] >= 1020 && m_word[2] <= 3 && m_word[3] <= 3;
        t = 0;
        if (hit) begin
          m_word[1] = 1023; m_word[2] = 0; m_word[3] = 0;
          m_tag[1] = 1; m_tag[2] = 1; m_tag[3] = 1;
          t = ((w / 16) % 2 == 1) ? 3 : 2;
        end
        void'(m_word.pop_front());
        void'(m_tag.pop_front());
        m_word.push_back(w);
        m_tag.push_back(t);
      end
      m_vld = word_in_vld;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      check("R1", "word_out", int'(word_out), 0);
      check("R1", "flags", int'({word_out_vld, trs_hit, trs_is_sav, trs_is_eav, active_video}), 0);
    end else if (!finished) begin
      string wreq;
      bit e_sav;
      bit e_eav;
      bit e_act;
      if (m_tag[0] == 1 && m_word[0] == 1023) wreq = "R3";
      else if (m_tag[0] == 1)                 wreq = "R4";
      else                                    wreq = phase;
      e_sav = m_vld && m_tag[0] == 2;
      e_eav = m_vld && m_tag[0] == 3;
      e_act = m_vld && m_act && m_tag[0] == 0;
      check(wreq, "word_out", int'(word_out), m_word[0]);
      check("R10", "word_out_vld", int'(word_out_vld), int'(m_vld));
      check((phase == "R7") ? "R7" : "R6", "trs_hit", int'(trs_hit), int'(e_sav || e_eav));
      check("R6", "trs_is_sav", int'(trs_is_sav), int'(e_sav));
      check("R6", "trs_is_eav", int'(trs_is_eav), int'(e_eav));
      check("R9", "active_video", int'(active_video), int'(e_act));
      if (trs_hit) hits_seen++;
      if (trs_is_sav) sav_seen++;
      if (trs_is_eav) eav_seen++;
    end
  end

  task automatic put(input int w, input bit v);
    @(posedge clk);
    #1;
    word_in = w[9:0];
    word_in_vld = v;
  endtask

  task automatic put_gappy(input int w);
    if ($urandom_range(0, 3) == 0) put(int'($urandom_range(0, 1023)), 1'b0);
    put(w, 1'b1);
  endtask

  task automatic flush(input int n);
    for (int i = 0; i < n; i++) put(16'h155, 1'b1);
    put(0, 1'b0);
  endtask

  task automatic send_ref(input int a, input int b, input int c, input int xyz);
    put_gappy(a); put_gappy(b); put_gappy(c); put_gappy(xyz);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: got hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R2 and R10: random words with random stalls.
    phase = "R2";
    for (int i = 0; i < 60; i++) put(int'($urandom_range(16, 1000)), 1'($urandom_range(0, 1)));
    flush(5);

    // R3, R4, R6, R9: noisy references framing an active region.
    phase = "R2";
    hits_seen = 0; sav_seen = 0; eav_seen = 0;
    send_ref(10'h3FE, 10'h002, 10'h001, 10'h200);
    for (int i = 0; i < 12; i++) put_gappy(int'($urandom_range(64, 900)));
    send_ref(10'h3FC, 10'h003, 10'h000, 10'h274);
    flush(6);
    check("R6", "start references seen", sav_seen, 1);
    check("R6", "end references seen", eav_seen, 1);

    // R5: near misses are left alone.
    phase = "R5";
    hits_seen = 0;
    send_ref(10'h3FB, 10'h000, 10'h000, 10'h2D0);
    send_ref(10'h3FF, 10'h004, 10'h000, 10'h2D0);
    send_ref(10'h3FF, 10'h000, 10'h3FF, 10'h2D0);
    flush(6);
    check("R5", "references seen on near misses", hits_seen, 0);

    // R7: detection off passes words through.
    phase = "R7";
    hits_seen = 0;
    put(0, 1'b0);
    det_enable_n = 1'b1;
    send_ref(10'h3FD, 10'h001, 10'h002, 10'h200);
    send_ref(10'h3FF, 10'h000, 10'h000, 10'h274);
    flush(6);
    check("R7", "references seen while off", hits_seen, 0);
    det_enable_n = 1'b0;

    // R8: narrow source words.
    phase = "R8";
    narrow_mode = 1'b1;
    for (int i = 0; i < 10; i++) put_gappy(int'($urandom_range(0, 1023)));
    send_ref(8'hFF, 8'h00, 8'h00, 8'h80);
    for (int i = 0; i < 6; i++) put_gappy(int'($urandom_range(20, 200)));
    send_ref(8'hFF, 8'h00, 8'h00, 8'h9D);
    put_gappy(8'hFF);
    flush(6);
    narrow_mode = 1'b0;

    // R9: a one-clock enable drop inside the active region.
    phase = "R2";
    send_ref(10'h3FF, 10'h000, 10'h000, 10'h200);
    for (int i = 0; i < 5; i++) put(int'($urandom_range(64, 900)), 1'b1);
    put(300, 1'b1);
    det_enable_n = 1'b1;
    put(301, 1'b1);
    det_enable_n = 1'b0;
    for (int i = 0; i < 6; i++) put(int'($urandom_range(64, 900)), 1'b1);
    send_ref(10'h3FF, 10'h001, 10'h003, 10'h274);
    flush(6);

    // Back-to-back references and mixed random traffic.
    for (int k = 0; k < 20; k++) begin
      send_ref(int'($urandom_range(1020, 1023)), int'($urandom_range(0, 3)),
               int'($urandom_range(0, 3)), int'($urandom_range(512, 1023)));
      for (int i = 0; i < int'($urandom_range(0, 4)); i++) put_gappy(int'($urandom_range(0, 1023)));
    end
    flush(6);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule